// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a three-wire stereo audio stream into parallel samples. The three wires are a bit clock, a left/right (frame) clock and a data line. The block samples all three wires on its own system clock. It finds the rising edges of the bit clock and reads the data and frame-clock levels at each of those edges.

Two 2-bit control inputs set how the block reads the stream. A format code chooses the framing and a width code chooses the word length. Both codes come from a control register elsewhere, and that register's reset value (both codes zero) means standard framing with 24-bit words. Each frame has a left word and a right word. Once both are captured, the block shows them together on two 24-bit outputs, packed toward the MSB, and pulses a strobe for one system clock.

After reset the block ignores the line until it sees the frame clock rise at a bit-clock edge. A frame clock that is already high when reset is released does not count as a rise.

The controller has three states:

- `ST_WAIT` is the idle state after reset. It moves to `ST_SEEK` on a frame-clock rise.
- `ST_SEEK` waits for a left word. It moves to `ST_PAIR` when a left word completes. A right word that completes in this state is dropped.
- `ST_PAIR` holds the left word and waits for the right one. It returns to `ST_SEEK` when the right word completes, and it raises the strobe in that same step. A new left word in `ST_PAIR` replaces the held one.

Top module: `aud_rx`

## Requirements
- R1: While reset is asserted, `valid` is 0 and both sample outputs are 0. After release, no word is captured until `lrclk` is seen going from low to high between two bit-clock rising edges.
- R2: With format code 00, a low `lrclk` is the left channel. The MSB is on the second bit-clock rising edge after a level change, and the N bits that follow it, MSB first, form the word.
- R3: With format code 11, a high `lrclk` is the left channel. The MSB is on the first bit-clock rising edge that shows the new level.
- R4: With format code 01, a high `lrclk` is the left channel. The word is the last N bits of each half-frame, with the LSB on the half-frame's final bit-clock edge. The word is taken at the next level change.
- R5: With format code 10, `lrclk` is high for exactly one bit clock to mark the frame start. The left MSB is on the next edge, and the right MSB follows directly after the left LSB.
- R6: Width code 00 selects N=24, code 01 selects N=20, and codes 10 and 11 both select N=16.
- R7: An N-bit word appears in bits 23 down to 24-N of its output. The remaining low bits are 0.
- R8: `valid` is high for one clock after the right word of a frame whose left word was captured. The outputs change only together with `valid`. A right word with no preceding left word raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every line is sampled on it |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | 2 | Framing code: 00 standard, 01 right-justified, 10 frame-sync, 11 left-justified |
| width_sel | input | 2 | Word length code: 00 24-bit, 01 20-bit, 1x 16-bit |
| bclk | input | 1 | Serial bit clock; data is read at its rising edge |
| lrclk | input | 1 | Left/right level or frame-sync pulse |
| sdata | input | 1 | Serial data, MSB first |
| left_out | output | 24 | Left sample, MSB-aligned |
| right_out | output | 24 | Right sample, MSB-aligned |
| valid | output | 1 | One-clock strobe when a new sample pair is presented |

## Verification
In right-justified framing, three things happen at the same bit-clock edge: the word latch, the half-frame counter restart and, for the right word, the strobe. The stimulus fills every half-frame to its 32-bit length with words of each width, and this forces all three to coincide. A scoreboard compares the latched pair against the values sent. In frame-sync mode the right word ends exactly 2N edges after the pulse while the next frame pulse is still pending, so the strobe timing and the restart are judged the same way across back-to-back frames.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

    typedef enum logic [1:0] {
        FMT_STD  = 2'b00,
        FMT_RJ   = 2'b01,
        FMT_SYNC = 2'b10,
        FMT_LJ   = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        ST_WAIT,
        ST_SEEK,
        ST_PAIR
    } rx_state_e;

    function automatic logic [4:0] word_len(input logic [1:0] code);
        logic [4:0] n;
        unique case (code)
            2'b00:   n = 5'd24;
            2'b01:   n = 5'd20;
            default: n = 5'd16;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/aud_rx_edge.sv
module aud_rx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic lrclk,
    output logic tick,
    output logic lr_chg,
    output logic lr_rise,
    output logic lr_prev
);
    logic bclk_q;
    logic lr_last;
    logic primed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q  <= 1'b0;
            lr_last <= 1'b0;
            primed  <= 1'b0;
        end else begin
            bclk_q <= bclk;
            if (tick) begin
                lr_last <= lrclk;
                primed  <= 1'b1;
            end
        end
    end

    always_comb begin
        tick    = bclk & ~bclk_q;
        lr_chg  = tick & primed & (lrclk ^ lr_last);
        lr_rise = tick & primed & lrclk & ~lr_last;
        lr_prev = lr_last;
    end
endmodule

// File: rtl/aud_rx_shift.sv
module aud_rx_shift #(
    parameter int W     = 24,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             din,
    input  logic             restart,
    output logic [W-1:0]     shift_q,
    output logic [CNT_W-1:0] cnt_now
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        if (restart)
            cnt_now = '0;
        else if (cnt_q == CNT_MAX)
            cnt_now = cnt_q;
        else
            cnt_now = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            cnt_q   <= '0;
        end else if (tick) begin
            shift_q <= {shift_q[W-2:0], din};
            cnt_q   <= cnt_now;
        end
    end
endmodule

// File: rtl/aud_rx.sv
module aud_rx
    import aud_rx_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int CNT_W    = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          fmt_sel,
    input  logic [1:0]          width_sel,
    input  logic                bclk,
    input  logic                lrclk,
    input  logic                sdata,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                valid
);
    localparam logic [CNT_W-1:0] OUT_W_C = CNT_W'(SAMPLE_W);

    fmt_e                fmt;
    rx_state_e           state, nxt;
    logic                tick, lr_chg, lr_rise, lr_prev;
    logic                frame_start;
    logic [SAMPLE_W-1:0] shift_q, ext, raw, aligned;
    logic [CNT_W-1:0]    cnt_now, wl, wl2, shamt;
    logic                left_done, right_done;
    logic [SAMPLE_W-1:0] left_hold;

    assign fmt         = fmt_e'(fmt_sel);
    assign frame_start = (fmt == FMT_SYNC) ? lr_rise : lr_chg;

    aud_rx_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .bclk    (bclk),
        .lrclk   (lrclk),
        .tick    (tick),
        .lr_chg  (lr_chg),
        .lr_rise (lr_rise),
        .lr_prev (lr_prev)
    );

    aud_rx_shift #(.W(SAMPLE_W), .CNT_W(CNT_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .din     (sdata),
        .restart (frame_start),
        .shift_q (shift_q),
        .cnt_now (cnt_now)
    );

    // word boundary decode per framing
    always_comb begin
        wl         = {{(CNT_W-5){1'b0}}, word_len(width_sel)};
        wl2        = {wl[CNT_W-2:0], 1'b0};
        shamt      = OUT_W_C - wl;
        ext        = {shift_q[SAMPLE_W-2:0], sdata};
        raw        = ext;
        left_done  = 1'b0;
        right_done = 1'b0;
        unique case (fmt)
            FMT_STD: begin
                left_done  = tick & (cnt_now == wl) & ~lrclk;
                right_done = tick & (cnt_now == wl) &  lrclk;
            end
            FMT_LJ: begin
                left_done  = tick & (cnt_now == wl - 1'b1) &  lrclk;
                right_done = tick & (cnt_now == wl - 1'b1) & ~lrclk;
            end
            FMT_RJ: begin
                raw        = shift_q;
                left_done  = lr_chg &  lr_prev;
                right_done = lr_chg & ~lr_prev;
            end
            FMT_SYNC: begin
                left_done  = tick & (cnt_now == wl);
                right_done = tick & (cnt_now == wl2);
            end
        endcase
        aligned = raw << shamt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_WAIT: if (lr_rise)    nxt = ST_SEEK;
            ST_SEEK: if (left_done)  nxt = ST_PAIR;
            ST_PAIR: if (right_done) nxt = ST_SEEK;
            default:                 nxt = ST_WAIT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_WAIT;
        else        state <= nxt;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_hold <= '0;
            left_out  <= '0;
            right_out <= '0;
            valid     <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (state != ST_WAIT && left_done)
                left_hold <= aligned;
            if (state == ST_PAIR && right_done) begin
                left_out  <= left_hold;
                right_out <= aligned;
                valid     <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/aud_rx_chk.sv
module aud_rx_chk
    import aud_rx_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          width_sel,
    input logic                valid,
    input logic [SAMPLE_W-1:0] left_out,
    input logic [SAMPLE_W-1:0] right_out,
    input rx_state_e           state
);
    p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    p_left_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(left_out) |-> valid);

    p_right_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(right_out) |-> valid);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |=> !valid);

    p_pad16_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && width_sel[1]) |->
            (left_out[SAMPLE_W-17:0] == '0 && right_out[SAMPLE_W-17:0] == '0));

    p_pad20_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && width_sel == 2'b01) |->
            (left_out[SAMPLE_W-21:0] == '0 && right_out[SAMPLE_W-21:0] == '0));
endmodule

bind aud_rx aud_rx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .width_sel (width_sel),
    .valid     (valid),
    .left_out  (left_out),
    .right_out (right_out),
    .state     (state)
);

// File: tb/sim_aud_rx.sv
module sim_aud_rx;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  fmt_sel, width_sel;
    logic        bclk, lrclk, sdata;
    logic [23:0] left_out, right_out;
    logic        valid;

    int n_chk  = 0;
    int n_fail = 0;
    logic [23:0] q_l[$];
    logic [23:0] q_r[$];
    string       q_tag[$];

    always #4 clk = ~clk;

    aud_rx u0 (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .width_sel(width_sel),
        .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
        .left_out(left_out), .right_out(right_out), .valid(valid)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%06h expected=%06h", tag, act, exp);
        end
    endtask

    function automatic int wlen(input logic [1:0] c);
        return (c == 2'b00) ? 24 : (c == 2'b01) ? 20 : 16;
    endfunction

    task automatic bit_tick(input logic lr, input logic d);
        @(negedge clk);
        bclk = 1'b0; lrclk = lr; sdata = d;
        @(negedge clk);
        @(negedge clk);
        bclk = 1'b1;
        @(negedge clk);
    endtask

    // driver: one 64-edge frame in the current format, expected pair queued
    task automatic send_frame(input logic [23:0] lv, input logic [23:0] rv, input string tag);
        int n;
        logic [23:0] lm, rm;
        n  = wlen(width_sel);
        lm = lv & 24'((1 << n) - 1);
        rm = rv & 24'((1 << n) - 1);
        q_l.push_back(lm << (24 - n));
        q_r.push_back(rm << (24 - n));
        q_tag.push_back(tag);
        for (int i = 0; i < 64; i++) begin
            int  j;
            int  c;
            logic lr, d;
            logic [23:0] w;
            j = i % 32;
            c = i / 32;
            w = (c == 0) ? lm : rm;
            d = 1'b0;
            unique case (fmt_sel)
                2'b00: begin lr = (c == 1); if (j >= 1 && j <= n) d = w[n - j]; end
                2'b11: begin lr = (c == 0); if (j < n) d = w[n - 1 - j]; end
                2'b01: begin lr = (c == 0); if (j >= 32 - n) d = w[31 - j]; end
                default: begin
                    lr = (i == 0);
                    if (i >= 1 && i <= n) d = lm[n - i];
                    else if (i > n && i <= 2 * n) d = rm[2 * n - i];
                end
            endcase
            bit_tick(lr, d);
        end
    endtask

    task automatic run_phase(input logic [1:0] f, input logic [1:0] wc,
                             input string tag, input logic [23:0] base);
        int n;
        rst_n = 1'b0; fmt_sel = f; width_sel = wc;
        bclk = 1'b0; lrclk = 1'b0; sdata = 1'b0;
        repeat (4) @(negedge clk);
        check(valid == 1'b0, {"R1 reset valid ", tag}, {23'd0, valid}, 24'd0);
        check(left_out == 24'd0, {"R1 reset left ", tag}, left_out, 24'd0);
        check(right_out == 24'd0, {"R1 reset right ", tag}, right_out, 24'd0);
        rst_n = 1'b1;
        n = wlen(wc);
        if (f == 2'b00) begin
            // junk left-level bits before any rise must not be captured (R1),
            // and the orphan right half after the rise gives no strobe (R8)
            for (int k = 0; k < 40; k++) bit_tick(1'b0, 1'b1);
            for (int k = 0; k < 32; k++) bit_tick(1'b1, 1'b1);
        end else begin
            for (int k = 0; k < 8; k++) bit_tick(1'b0, 1'b1);
        end
        send_frame(base, ~base, tag);
        send_frame(24'hFFFFFF, 24'h000001, tag);
        send_frame(24'(1 << (n - 1)), 24'h000000, tag);
        for (int k = 0; k < 8; k++)
            bit_tick((f == 2'b01 || f == 2'b11), 1'b0);
        repeat (8) @(negedge clk);
        check(q_l.size() == 0, {"R8 all pairs delivered ", tag},
              24'(q_l.size()), 24'd0);
        q_l.delete(); q_r.delete(); q_tag.delete();
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n === 1'b1 && valid === 1'b1) begin
            if (q_l.size() == 0) begin
                check(1'b0, "R8 R1 strobe with nothing expected", left_out, 24'd0);
            end else begin
                logic [23:0] el, er;
                string       t;
                el = q_l.pop_front();
                er = q_r.pop_front();
                t  = q_tag.pop_front();
                check(left_out == el, {t, " left R6 R7"}, left_out, el);
                check(right_out == er, {t, " right R6 R7"}, right_out, er);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 24'd0, 24'd1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        run_phase(2'b00, 2'b00, "R2 std/24",   24'hA5C3E1);
        run_phase(2'b11, 2'b01, "R3 lj/20",    24'h3C96F2);
        run_phase(2'b01, 2'b10, "R4 rj/16",    24'h00B7D4);
        run_phase(2'b10, 2'b11, "R5 sync/16",  24'h5E2A19);
        run_phase(2'b00, 2'b01, "R2 std/20",   24'h71D08B);
        run_phase(2'b01, 2'b00, "R4 rj/24",    24'hC4E817);
        run_phase(2'b10, 2'b00, "R5 sync/24",  24'h9A0F63);
        run_phase(2'b11, 2'b11, "R3 lj/16",    24'h2BD74E);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule